// File: doc/BRIEF.md
# Interrupt Acknowledge Controller

This block collects a parameterized number of level-sensitive interrupt sources for one CPU and presents them to software through a small 32-bit register bus. Each source has an enable bit and a target word. The enable bits are set through one bank of write-one registers and cleared through a second bank. A source takes part only when it is enabled, its line is high, and bit 0 of its target word (CPU 0) is set. Two inter-processor interrupt flags, one for an interrupt a core sent to itself and one for an interrupt from another core, have their own set, clear, enable and disable registers.

Software takes events by reading the acknowledge register until it returns zero. Each read returns a typed, numbered event word and removes that event in the same cycle. An acknowledged IPI flag is cleared. An acknowledged external source has its enable bit cleared, so a line that is still held high stays quiet until software enables it again. A single registered request output tells the CPU that an eligible event is waiting.

Internally, every bus cycle is sorted into one of four operations: OP_IDLE (no request), OP_WRITE (write request), OP_READ (read of any address other than the acknowledge register) and OP_ACK (read of the acknowledge register). The operation is chosen again on every cycle. No state is carried from one request to the next, and the only transitions are from the current bus inputs to one of these four operations. NUM_SRC may be at most 1024, so the target-word window stays below the enable banks.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, irq_out is 0, an acknowledge read returns 0, and every enable word, target word, IPI flag and IPI enable reads as 0.
- R2: A read of offset 0x0004 returns NUM_SRC in bits 15:0, with bits 31:16 at zero.
- R3: A write to 0x4180+4k enables source 32k+b for every set bit b. A write to 0x4100+4k disables it. Zero bits change nothing. A read of either address returns the current enable word of bank k.
- R4: Offset 0x3000+4n holds the target word of source n. The low AFF_W bits are stored and read back, zero-extended. A source is eligible only when bit 0 of its target word is set.
- R5: The acknowledge read at 0x2004 carries the event kind in bits 19:16 (0 = none, 1 = external, 4 = IPI) and the source number in bits 11:0. An external source n reads as 0x10000+n, a self IPI as 0x40002 and an other-core IPI as 0x40001.
- R6: When several events are eligible, the acknowledge read reports the self IPI first, then the other-core IPI, then the external source with the lowest number.
- R7: An acknowledge read that reports external source n clears the enable bit of n. A line that stays high is then not reported again.
- R8: A write to 0x2008 sets, and a write to 0x200C clears, the self IPI flag (bit 31) and the other-core IPI flag (bit 0). Writes to 0x2028 and 0x2024 enable and disable the same two bits. Reads of 0x2008 and 0x2028 return the flags and the enables. A disabled flag stays pending but is not reported. Acknowledging an IPI clears its flag.
- R9: irq_out is registered. It reflects whether an eligible event exists one rising edge after the state or the source lines change.
- R10: Read data appears on bus_rdata at the rising edge that captures the request and is held until the next read. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_level | input | NUM_SRC | Level-sensitive source lines |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
A request is captured at a rising edge. Its read data, and any change it makes to the enable bits or the IPI flags, become visible at that same edge, so the bench samples bus_rdata at the falling edge right after it. irq_out lags by one more edge. Every check of it therefore waits one further falling edge after the access or the source-line change, and one check samples it before that edge to confirm it has not yet moved. The sweeps step through every source number and several line patterns, and they compute the expected acknowledge words from the source number and the priority order.

// File: rtl/irqack_pkg.sv
package irqack_pkg;

    localparam logic [15:0] OFS_CONFIG   = 16'h0004;
    localparam logic [15:0] OFS_ACK      = 16'h2004;
    localparam logic [15:0] OFS_IPI_SET  = 16'h2008;
    localparam logic [15:0] OFS_IPI_CLR  = 16'h200C;
    localparam logic [15:0] OFS_IPI_DIS  = 16'h2024;
    localparam logic [15:0] OFS_IPI_ENA  = 16'h2028;
    localparam logic [15:0] OFS_AFF_BASE = 16'h3000;
    localparam logic [15:0] OFS_DIS_BASE = 16'h4100;
    localparam logic [15:0] OFS_ENA_BASE = 16'h4180;

    localparam int IPI_SELF_BIT  = 31;
    localparam int IPI_OTHER_BIT = 0;

    localparam logic [11:0] NUM_IPI_OTHER = 12'd1;
    localparam logic [11:0] NUM_IPI_SELF  = 12'd2;

    typedef enum logic [3:0] {
        KIND_NONE = 4'd0,
        KIND_EXT  = 4'd1,
        KIND_IPI  = 4'd4
    } evt_kind_e;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_SELF,
        WIN_OTHER,
        WIN_EXT
    } winner_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_WRITE,
        OP_READ,
        OP_ACK
    } bus_op_e;

    function automatic logic [31:0] pack_ack(evt_kind_e kind, logic [11:0] num);
        return {12'd0, kind, 4'd0, num};
    endfunction

endpackage

// File: rtl/irqack_src_bank.sv
module irqack_src_bank
    import irqack_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int AFF_W   = 8,
    parameter int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [15:0]        addr,
    input  logic [31:0]        wdata,
    input  logic               ack_clr,
    input  logic [SRC_W-1:0]   ack_idx,
    output logic [NUM_SRC-1:0] en_vec,
    output logic [NUM_SRC-1:0] tgt_vec,
    output logic               rd_hit,
    output logic [31:0]        rd_word
);

    localparam int NUM_BANK = (NUM_SRC + 31) / 32;

    logic [AFF_W-1:0]       aff_arr [NUM_SRC];
    logic [NUM_BANK*32-1:0] en_pad;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int BK = i / 32;
        localparam int BT = i % 32;
        localparam logic [15:0] A_AFF = OFS_AFF_BASE + 16'(4 * i);
        localparam logic [15:0] A_DIS = OFS_DIS_BASE + 16'(4 * BK);
        localparam logic [15:0] A_ENA = OFS_ENA_BASE + 16'(4 * BK);

        logic             en_q;
        logic [AFF_W-1:0] aff_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= 1'b0;
            end else if (ack_clr && ack_idx == SRC_W'(i)) begin
                en_q <= 1'b0;
            end else if (wr_en && addr == A_DIS && wdata[BT]) begin
                en_q <= 1'b0;
            end else if (wr_en && addr == A_ENA && wdata[BT]) begin
                en_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                aff_q <= '0;
            end else if (wr_en && addr == A_AFF) begin
                aff_q <= wdata[AFF_W-1:0];
            end
        end

        assign en_vec[i]  = en_q;
        assign tgt_vec[i] = aff_q[0];
        assign aff_arr[i] = aff_q;
    end

    always_comb begin
        en_pad = '0;
        en_pad[NUM_SRC-1:0] = en_vec;
    end

    always_comb begin
        rd_hit  = 1'b0;
        rd_word = '0;
        if (addr[1:0] == 2'b00 && addr >= OFS_AFF_BASE &&
            addr < OFS_AFF_BASE + 16'(4 * NUM_SRC)) begin
            rd_hit  = 1'b1;
            rd_word = 32'(aff_arr[SRC_W'((addr - OFS_AFF_BASE) >> 2)]);
        end else begin
            for (int k = 0; k < NUM_BANK; k++) begin
                if (addr == OFS_DIS_BASE + 16'(4 * k) ||
                    addr == OFS_ENA_BASE + 16'(4 * k)) begin
                    rd_hit  = 1'b1;
                    rd_word = en_pad[k*32 +: 32];
                end
            end
        end
    end

    // R7
    ext_ack_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_clr |=> !en_vec[$past(ack_idx)]);

endmodule

// File: rtl/irqack_ipi.sv
module irqack_ipi (
    input  logic clk,
    input  logic rst_n,
    input  logic set_wr,
    input  logic clr_wr,
    input  logic ena_wr,
    input  logic dis_wr,
    input  logic bit_self,
    input  logic bit_other,
    input  logic ack_self,
    input  logic ack_other,
    output logic self_pend,
    output logic other_pend,
    output logic self_ena,
    output logic other_ena
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            self_pend  <= 1'b0;
            other_pend <= 1'b0;
        end else begin
            if (ack_self || (clr_wr && bit_self)) begin
                self_pend <= 1'b0;
            end else if (set_wr && bit_self) begin
                self_pend <= 1'b1;
            end
            if (ack_other || (clr_wr && bit_other)) begin
                other_pend <= 1'b0;
            end else if (set_wr && bit_other) begin
                other_pend <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            self_ena  <= 1'b0;
            other_ena <= 1'b0;
        end else begin
            if (dis_wr && bit_self) begin
                self_ena <= 1'b0;
            end else if (ena_wr && bit_self) begin
                self_ena <= 1'b1;
            end
            if (dis_wr && bit_other) begin
                other_ena <= 1'b0;
            end else if (ena_wr && bit_other) begin
                other_ena <= 1'b1;
            end
        end
    end

    // R8
    ipi_self_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_self |=> !self_pend);

    // R8
    ipi_other_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_other |=> !other_pend);

endmodule

// File: rtl/irqack_pick.sv
module irqack_pick
    import irqack_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               self_pend,
    input  logic               other_pend,
    input  logic               self_ena,
    input  logic               other_ena,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic [NUM_SRC-1:0] en_vec,
    input  logic [NUM_SRC-1:0] tgt_vec,
    output winner_e            winner,
    output logic [SRC_W-1:0]   ext_idx,
    output logic               any_evt
);

    logic [NUM_SRC-1:0] elig;
    logic               ext_found;

    assign elig = src_level & en_vec & tgt_vec;

    always_comb begin
        ext_found = 1'b0;
        ext_idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                ext_found = 1'b1;
                ext_idx   = SRC_W'(i);
            end
        end
    end

    always_comb begin
        if (self_pend && self_ena) begin
            winner = WIN_SELF;
        end else if (other_pend && other_ena) begin
            winner = WIN_OTHER;
        end else if (ext_found) begin
            winner = WIN_EXT;
        end else begin
            winner = WIN_NONE;
        end
    end

    assign any_evt = (winner != WIN_NONE);

    // R6
    ext_pick_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (winner == WIN_EXT) |-> (src_level[ext_idx] && en_vec[ext_idx] && tgt_vec[ext_idx]));

    // R6
    ext_after_ipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (winner == WIN_EXT) |-> !(self_pend && self_ena) && !(other_pend && other_ena));

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irqack_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int AFF_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [15:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_level,
    output logic               irq_out
);

    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    bus_op_e            op;
    winner_e            winner;
    logic [SRC_W-1:0]   ext_idx;
    logic               any_evt;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] tgt_vec;
    logic               bank_hit;
    logic [31:0]        bank_word;
    logic               self_pend, other_pend, self_ena, other_ena;
    logic               wr_en, ack_do;
    logic [31:0]        ack_word;
    logic [31:0]        rd_next;
    logic [31:0]        rdata_q;
    logic               irq_q;

    always_comb begin
        unique case ({bus_req, bus_we})
            2'b11:   op = OP_WRITE;
            2'b10:   op = (bus_addr == OFS_ACK) ? OP_ACK : OP_READ;
            default: op = OP_IDLE;
        endcase
    end

    assign wr_en  = (op == OP_WRITE);
    assign ack_do = (op == OP_ACK);

    irqack_src_bank #(
        .NUM_SRC (NUM_SRC),
        .AFF_W   (AFF_W),
        .SRC_W   (SRC_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .ack_clr (ack_do && winner == WIN_EXT),
        .ack_idx (ext_idx),
        .en_vec  (en_vec),
        .tgt_vec (tgt_vec),
        .rd_hit  (bank_hit),
        .rd_word (bank_word)
    );

    irqack_ipi u_ipi (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_wr     (wr_en && bus_addr == OFS_IPI_SET),
        .clr_wr     (wr_en && bus_addr == OFS_IPI_CLR),
        .ena_wr     (wr_en && bus_addr == OFS_IPI_ENA),
        .dis_wr     (wr_en && bus_addr == OFS_IPI_DIS),
        .bit_self   (bus_wdata[IPI_SELF_BIT]),
        .bit_other  (bus_wdata[IPI_OTHER_BIT]),
        .ack_self   (ack_do && winner == WIN_SELF),
        .ack_other  (ack_do && winner == WIN_OTHER),
        .self_pend  (self_pend),
        .other_pend (other_pend),
        .self_ena   (self_ena),
        .other_ena  (other_ena)
    );

    irqack_pick #(
        .NUM_SRC (NUM_SRC),
        .SRC_W   (SRC_W)
    ) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .self_pend  (self_pend),
        .other_pend (other_pend),
        .self_ena   (self_ena),
        .other_ena  (other_ena),
        .src_level  (src_level),
        .en_vec     (en_vec),
        .tgt_vec    (tgt_vec),
        .winner     (winner),
        .ext_idx    (ext_idx),
        .any_evt    (any_evt)
    );

    always_comb begin
        unique case (winner)
            WIN_SELF:  ack_word = pack_ack(KIND_IPI, NUM_IPI_SELF);
            WIN_OTHER: ack_word = pack_ack(KIND_IPI, NUM_IPI_OTHER);
            WIN_EXT:   ack_word = pack_ack(KIND_EXT, 12'(ext_idx));
            default:   ack_word = pack_ack(KIND_NONE, 12'd0);
        endcase
    end

    always_comb begin
        rd_next = '0;
        if (op == OP_ACK) begin
            rd_next = ack_word;
        end else if (bus_addr == OFS_CONFIG) begin
            rd_next = {16'd0, 16'(NUM_SRC)};
        end else if (bus_addr == OFS_IPI_SET) begin
            rd_next[IPI_SELF_BIT]  = self_pend;
            rd_next[IPI_OTHER_BIT] = other_pend;
        end else if (bus_addr == OFS_IPI_ENA) begin
            rd_next[IPI_SELF_BIT]  = self_ena;
            rd_next[IPI_OTHER_BIT] = other_ena;
        end else if (bank_hit) begin
            rd_next = bank_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (op == OP_READ || op == OP_ACK) begin
            rdata_q <= rd_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= any_evt;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq_out   = irq_q;

    // R5
    ack_kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_do |=> (bus_rdata[19:16] == 4'd0 || bus_rdata[19:16] == 4'd1 ||
                    bus_rdata[19:16] == 4'd4));

    // R5
    empty_ack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_do && !any_evt) |=> (bus_rdata == 32'd0));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE || op == OP_WRITE) |=> $stable(bus_rdata));

endmodule

// File: tb/test_irq_ack_ctrl.sv
`timescale 1ns/1ps
module test_irq_ack_ctrl;

    localparam int N     = 64;
    localparam int AFF_W = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_req;
    logic          bus_we;
    logic [15:0]   bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  src_level;
    logic          irq_out;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    irq_ack_ctrl #(.NUM_SRC(N), .AFF_W(AFF_W)) i_irq_ack_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_level (src_level),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_req = 1'b0;
    endtask

    function automatic logic [15:0] ena_addr(input int n);
        return 16'h4180 + 16'(4 * (n / 32));
    endfunction

    function automatic logic [15:0] dis_addr(input int n);
        return 16'h4100 + 16'(4 * (n / 32));
    endfunction

    task automatic disable_all();
        wr(16'h4100, 32'hFFFF_FFFF);
        wr(16'h4104, 32'hFFFF_FFFF);
    endtask

    task automatic prio_pattern(input int mode);
        logic [31:0] v;
        for (int n = 0; n < N; n++)
            src_level[n] = (mode == 0) ? ((n % 3 == 0) || n == N - 1) : (n % 5 == 2);
        wr(16'h4180, 32'hFFFF_FFFF);
        wr(16'h4184, 32'hFFFF_FFFF);
        for (int n = 0; n < N; n++) begin
            if (src_level[n]) begin
                rd(16'h2004, v);
                check($sformatf("R6 priority mode %0d src %0d", mode, n), v, 32'h0001_0000 + 32'(n));
            end
        end
        rd(16'h2004, v);
        check("R6 priority drained", v, 32'd0);
        disable_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0; src_level = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 irq_out after reset", 32'(irq_out), 32'd0);
        rd(16'h2004, v); check("R1 ack empty", v, 32'd0);
        rd(16'h4100, v); check("R1 enable bank0", v, 32'd0);
        rd(16'h4184, v); check("R1 enable bank1", v, 32'd0);
        rd(16'h3000, v); check("R1 target src0", v, 32'd0);
        rd(16'h30FC, v); check("R1 target src63", v, 32'd0);
        rd(16'h2008, v); check("R1 ipi flags", v, 32'd0);
        rd(16'h2028, v); check("R1 ipi enables", v, 32'd0);

        // R2 config
        rd(16'h0004, v); check("R2 config count", v, 32'(N));

        // R3 enable/disable banks
        src_level = '0;
        wr(16'h4180, 32'hA5A5_0001);
        rd(16'h4100, v); check("R3 enable set", v, 32'hA5A5_0001);
        wr(16'h4180, 32'h0000_0000);
        rd(16'h4180, v); check("R3 zero write no effect", v, 32'hA5A5_0001);
        wr(16'h4100, 32'h0000_0001);
        rd(16'h4180, v); check("R3 disable one bit", v, 32'hA5A5_0000);
        wr(16'h4184, 32'h8000_0002);
        rd(16'h4104, v); check("R3 bank1 enable", v, 32'h8000_0002);
        rd(16'h4100, v); check("R3 bank0 untouched", v, 32'hA5A5_0000);
        disable_all();
        rd(16'h4100, v); check("R3 bank0 cleared", v, 32'd0);
        rd(16'h4104, v); check("R3 bank1 cleared", v, 32'd0);

        // R4 target words, R10 unmapped
        wr(16'h3014, 32'hFFFF_FFFF);
        rd(16'h3014, v); check("R4 target width", v, 32'((1 << AFF_W) - 1));
        rd(16'h3100, v); check("R10 past target window", v, 32'd0);
        rd(16'h0100, v); check("R10 unmapped", v, 32'd0);
        @(negedge clk);
        check("R10 rdata held", bus_rdata, 32'd0);
        rd(16'h0004, v);
        @(negedge clk); @(negedge clk);
        check("R10 rdata held after idle", bus_rdata, 32'(N));

        // sweep every source
        for (int n = 0; n < N; n++) wr(16'h3000 + 16'(4 * n), 32'd1);
        src_level = '1;
        for (int n = 0; n < N; n++) begin
            wr(ena_addr(n), 32'd1 << (n % 32));
            @(negedge clk);
            check($sformatf("R9 irq high src %0d", n), 32'(irq_out), 32'd1);
            rd(16'h2004, v);
            check($sformatf("R5 ack word src %0d", n), v, 32'h0001_0000 + 32'(n));
            rd(16'h2004, v);
            check($sformatf("R7 no refire src %0d", n), v, 32'd0);
            rd(ena_addr(n), v);
            check($sformatf("R7 enable cleared src %0d", n), v, 32'd0);
            check($sformatf("R9 irq low src %0d", n), 32'(irq_out), 32'd0);
        end

        // R4 target bit 0 gates eligibility
        wr(16'h301C, 32'd2);
        wr(16'h4180, 32'h0000_0080);
        rd(16'h2004, v); check("R4 non-cpu0 target ignored", v, 32'd0);
        rd(16'h301C, v); check("R4 target readback", v, 32'd2);
        wr(16'h301C, 32'd1);
        rd(16'h2004, v); check("R4 cpu0 target reported", v, 32'h0001_0007);

        // R6 priority sweeps
        prio_pattern(0);
        prio_pattern(1);

        // R8 IPI flags
        src_level = '0;
        src_level[3] = 1'b1;
        wr(16'h4180, 32'h0000_0008);
        wr(16'h2008, 32'h8000_0001);
        rd(16'h2008, v); check("R8 ipi flags set", v, 32'h8000_0001);
        wr(16'h4100, 32'h0000_0008);
        rd(16'h2004, v); check("R8 disabled ipi not reported", v, 32'd0);
        @(negedge clk);
        check("R8 irq low with disabled ipi", 32'(irq_out), 32'd0);
        wr(16'h4180, 32'h0000_0008);
        wr(16'h2028, 32'h8000_0001);
        rd(16'h2028, v); check("R8 ipi enables", v, 32'h8000_0001);
        rd(16'h2004, v); check("R6 self ipi first", v, 32'h0004_0002);
        rd(16'h2004, v); check("R6 other ipi second", v, 32'h0004_0001);
        rd(16'h2004, v); check("R6 external last", v, 32'h0001_0003);
        rd(16'h2004, v); check("R5 drained", v, 32'd0);
        rd(16'h2008, v); check("R8 ack cleared flags", v, 32'd0);
        wr(16'h2008, 32'h0000_0001);
        wr(16'h200C, 32'h0000_0001);
        rd(16'h2008, v); check("R8 clear other", v, 32'd0);
        wr(16'h2024, 32'h8000_0000);
        rd(16'h2028, v); check("R8 disable self", v, 32'h0000_0001);
        wr(16'h2008, 32'h8000_0001);
        rd(16'h2004, v); check("R8 only enabled ipi", v, 32'h0004_0001);
        rd(16'h2008, v); check("R8 self stays pending", v, 32'h8000_0000);
        wr(16'h200C, 32'h8000_0000);

        // R9 irq timing on a line change
        src_level = '0;
        wr(dis_addr(9), 32'hFFFF_FFFF);
        wr(ena_addr(9), 32'd1 << 9);
        rd(16'h2004, v); check("R9 low line not reported", v, 32'd0);
        @(negedge clk);
        src_level[9] = 1'b1;
        #0.1;
        check("R9 irq before edge", 32'(irq_out), 32'd0);
        @(negedge clk);
        check("R9 irq one edge later", 32'(irq_out), 32'd1);
        rd(16'h2004, v); check("R5 line source reported", v, 32'h0001_0009);

        // R9 irq timing after a write
        wr(ena_addr(9), 32'd1 << 9);
        check("R9 irq not yet after write", 32'(irq_out), 32'd0);
        @(negedge clk);
        check("R9 irq after write", 32'(irq_out), 32'd1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule